// File: doc/BRIEF.md
# Interrupt Entry and Return Controller

This block is the trap-entry side of a small 32-bit RISC core. Thirty-two level-sensitive request lines are captured into a sticky pending register. A per-line mask and one global enable bit qualify them. Whenever the global enable is set and any masked-in pending bit is high, the controller asks the pipeline to redirect. It does so in the same cycle. Every source lands on one shared handler address, which is a fixed offset of 0xC0 above a programmable, 256-byte aligned base. In that cycle the controller also asks for the next-instruction address to be written into the exception-address general register.

On entry the global enable is moved into a saved-enable bit and then cleared. A second entry therefore cannot happen until the handler executes an exception return. The return restores the enable from the saved bit and redirects to the exception-address register value, which the pipeline presents on an input. Handler software reads the pending and mask registers through a plain control-register port and picks the source to serve.

All pins are plain control and data signals that are sampled every cycle. There is no valid/ready handshake, because the pipeline must act on a redirect in the cycle it is raised and cannot apply back-pressure to it.

Top module: `irq_entry_ctl`

## Requirements
- R1: A high level on request line i sets pending bit i at the next clock edge, and the bit stays set after the line drops.
- R2: A control write to address 2 clears every pending bit written as 1. A line that is still high in that cycle keeps its bit set.
- R3: While the global enable is 1 and (pending AND mask) is nonzero, redirect_o and ea_we_o are 1 in that same cycle. Otherwise no entry is signalled.
- R4: On entry, redirect_pc_o equals the base register plus 0xC0.
- R5: On entry, ea_wdata_o equals pc_next_i.
- R6: After an entry the global enable reads 0 and the saved-enable bit holds the enable's prior value. Pending bits stay latched, and no further entry occurs while the enable is 0.
- R7: When eret_i is high and no entry is taken, redirect_o is 1 with redirect_pc_o equal to ea_rdata_i and ea_we_o is 0. At the next edge the global enable takes the saved-enable value.
- R8: Writes to the base register (address 3) ignore bits 7:0, which always read 0.
- R9: After reset the status, mask, pending and base registers all read 0 and no redirect is requested.
- R10: The read port is combinational. Address 0 is status (bit 0 global enable, bit 1 saved enable), 1 is mask, 2 is pending, 3 is base, and every other address reads 0.
- R11: An entry or return in the same cycle as a status write overrides that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 32 | Level interrupt requests |
| pc_next_i | input | 32 | Address of the instruction that would run next |
| eret_i | input | 1 | Exception-return request from decode |
| ea_rdata_i | input | 32 | Current value of the exception-address register |
| csr_we_i | input | 1 | Control-register write strobe |
| csr_addr_i | input | 3 | Control-register address |
| csr_wdata_i | input | 32 | Control-register write data |
| csr_rdata_o | output | 32 | Control-register read data |
| redirect_o | output | 1 | Redirect the fetch this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| ea_we_o | output | 1 | Write the exception-address register |
| ea_wdata_o | output | 32 | Return address to write |

## Verification
The entry path is tried with requests that are unmasked, masked-out, raised while the enable is off, and raised under two different base values, so a missing mask, a missing enable gate or a wrong offset each give a distinct mismatch. A request still high during a clear-write separates a correct set-wins pending bit from a clear-wins bit. Status writes that coincide with an entry and with a return show whether hardware updates really override software. A return with the saved bit set, and one with it clear, show that the enable is restored and not simply set.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int CSR_AW = 3;

  typedef enum logic [CSR_AW-1:0] {
    CSR_STAT = 3'd0,
    CSR_MASK = 3'd1,
    CSR_PEND = 3'd2,
    CSR_BASE = 3'd3
  } csr_sel_e;

  localparam int STAT_IE  = 0;
  localparam int STAT_EIE = 1;
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int N_IRQ = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             clr_en_i,
  input  logic [N_IRQ-1:0] clr_mask_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] pend_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend_q[g] <= 1'b0;
      else if (irq_i[g])
        pend_q[g] <= 1'b1;                 // set wins over clear
      else if (clr_en_i && clr_mask_i[g])
        pend_q[g] <= 1'b0;
    end

    a_r1_level_latches: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i[g] |=> pend_q[g]);
    a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && clr_mask_i[g] && !irq_i[g]) |=> !pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int N_IRQ    = 32,
  parameter int BASE_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stat_i,
  input  logic             wr_mask_i,
  input  logic             wr_base_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             take_i,
  input  logic             ret_i,
  output logic             ie_o,
  output logic             eie_o,
  output logic [N_IRQ-1:0] mask_o,
  output logic [XLEN-1:0]  base_o
);
  localparam int HI_W = XLEN - BASE_LSB;

  logic             ie_q, eie_q;
  logic [N_IRQ-1:0] mask_q;
  logic [HI_W-1:0]  base_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      eie_q <= 1'b0;
    end else if (take_i) begin
      eie_q <= ie_q;
      ie_q  <= 1'b0;
    end else if (ret_i) begin
      ie_q  <= eie_q;
    end else if (wr_stat_i) begin
      ie_q  <= wdata_i[STAT_IE];
      eie_q <= wdata_i[STAT_EIE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      base_hi_q <= '0;
    end else begin
      if (wr_mask_i) mask_q    <= wdata_i[N_IRQ-1:0];
      if (wr_base_i) base_hi_q <= wdata_i[XLEN-1:BASE_LSB];
    end
  end

  assign ie_o   = ie_q;
  assign eie_o  = eie_q;
  assign mask_o = mask_q;
  assign base_o = {base_hi_q, {BASE_LSB{1'b0}}};

  a_r6_entry_saves_enable: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (!ie_q && eie_q == $past(ie_q)));
  a_r7_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> (ie_q == $past(eie_q)));
  a_r11_hw_over_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && wr_stat_i) |=> !ie_q);
  a_r8_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base_i |=> (base_o[XLEN-1:BASE_LSB] == $past(wdata_i[XLEN-1:BASE_LSB])));
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int                  XLEN     = 32,
  parameter int                  N_IRQ    = 32,
  parameter int                  BASE_LSB = 8,
  parameter logic [BASE_LSB-1:0] VEC_OFF  = 8'hC0
) (
  input  logic             ie_i,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic             eret_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  pc_next_i,
  input  logic [XLEN-1:0]  ea_rdata_i,
  output logic             take_o,
  output logic             ret_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             ea_we_o,
  output logic [XLEN-1:0]  ea_wdata_o
);
  logic             any_live;
  logic [XLEN-1:0]  vector_pc;

  always_comb begin
    any_live  = |(pend_i & mask_i);
    take_o    = ie_i && any_live;
    ret_o     = eret_i && !take_o;
    // base is aligned, so concatenation replaces an adder
    vector_pc = {base_i[XLEN-1:BASE_LSB], VEC_OFF};
    redirect_o    = take_o || ret_o;
    redirect_pc_o = take_o ? vector_pc : ea_rdata_i;
    ea_we_o       = take_o;
    ea_wdata_o    = pc_next_i;
  end
endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
  import irq_entry_pkg::*;
#(
  parameter int                  XLEN     = 32,
  parameter int                  BASE_LSB = 8,
  parameter logic [BASE_LSB-1:0] VEC_OFF  = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   irq_i,
  input  logic [XLEN-1:0]   pc_next_i,
  input  logic              eret_i,
  input  logic [XLEN-1:0]   ea_rdata_i,
  input  logic              csr_we_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              ea_we_o,
  output logic [XLEN-1:0]   ea_wdata_o
);
  localparam int N_IRQ = XLEN;

  csr_sel_e         sel;
  logic             wr_stat, wr_mask, wr_pend, wr_base;
  logic             ie_w, eie_w, take_w, ret_w;
  logic [N_IRQ-1:0] pend_w, mask_w;
  logic [XLEN-1:0]  base_w;

  always_comb begin
    sel     = csr_sel_e'(csr_addr_i);
    wr_stat = csr_we_i && (sel == CSR_STAT);
    wr_mask = csr_we_i && (sel == CSR_MASK);
    wr_pend = csr_we_i && (sel == CSR_PEND);
    wr_base = csr_we_i && (sel == CSR_BASE);
  end

  irq_pending_bank #(.N_IRQ(N_IRQ)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .clr_en_i   (wr_pend),
    .clr_mask_i (csr_wdata_i[N_IRQ-1:0]),
    .pend_o     (pend_w)
  );

  irq_status_regs #(.XLEN(XLEN), .N_IRQ(N_IRQ), .BASE_LSB(BASE_LSB)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stat_i (wr_stat),
    .wr_mask_i (wr_mask),
    .wr_base_i (wr_base),
    .wdata_i   (csr_wdata_i),
    .take_i    (take_w),
    .ret_i     (ret_w),
    .ie_o      (ie_w),
    .eie_o     (eie_w),
    .mask_o    (mask_w),
    .base_o    (base_w)
  );

  irq_accept #(.XLEN(XLEN), .N_IRQ(N_IRQ), .BASE_LSB(BASE_LSB), .VEC_OFF(VEC_OFF)) u_acc (
    .ie_i          (ie_w),
    .pend_i        (pend_w),
    .mask_i        (mask_w),
    .eret_i        (eret_i),
    .base_i        (base_w),
    .pc_next_i     (pc_next_i),
    .ea_rdata_i    (ea_rdata_i),
    .take_o        (take_w),
    .ret_o         (ret_w),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .ea_we_o       (ea_we_o),
    .ea_wdata_o    (ea_wdata_o)
  );

  always_comb begin
    csr_rdata_o = '0;
    case (sel)
      CSR_STAT: begin
        csr_rdata_o[STAT_IE]  = ie_w;
        csr_rdata_o[STAT_EIE] = eie_w;
      end
      CSR_MASK: csr_rdata_o = mask_w;
      CSR_PEND: csr_rdata_o = pend_w;
      CSR_BASE: csr_rdata_o = base_w;
      default:  csr_rdata_o = '0;
    endcase
  end

  a_r4_vector_target: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we_o |-> (redirect_pc_o == base_w + XLEN'(VEC_OFF)));
  a_r3_entry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we_o |-> (ie_w && ((pend_w & mask_w) != '0)));
  a_r6_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we_o |=> !ea_we_o);
  a_r5_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we_o |-> (ea_wdata_o == pc_next_i));
  a_r7_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !ea_we_o) |-> (eret_i && redirect_pc_o == ea_rdata_i));
endmodule

// File: tb/irq_entry_ctl_tb.sv
module irq_entry_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_i = '0;
  logic [31:0] pc_next_i = '0;
  logic        eret_i = 1'b0;
  logic [31:0] ea_rdata_i = '0;
  logic        csr_we_i = 1'b0;
  logic [2:0]  csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic        ea_we_o;
  logic [31:0] ea_wdata_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] target;
    logic        we;
    logic [31:0] ea;
  } redir_t;
  redir_t exp_q[$];

  always #10 clk = ~clk;

  irq_entry_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .pc_next_i(pc_next_i),
    .eret_i(eret_i), .ea_rdata_i(ea_rdata_i), .csr_we_i(csr_we_i),
    .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .ea_we_o(ea_we_o), .ea_wdata_o(ea_wdata_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every redirect must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && redirect_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R3/R6 unexpected redirect", redirect_pc_o, 32'h0);
      end else begin
        redir_t e;
        e = exp_q.pop_front();
        check(redirect_pc_o == e.target, "R4/R7 redirect target", redirect_pc_o, e.target);
        check(ea_we_o == e.we, "R3/R7 ea write enable", {31'b0, ea_we_o}, {31'b0, e.we});
        if (e.we) check(ea_wdata_o == e.ea, "R5 return address", ea_wdata_o, e.ea);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
    tick();
    csr_we_i = 1'b0; csr_wdata_i = '0;
  endtask

  task automatic csr_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    csr_addr_i = a; #2;
    check(csr_rdata_o == exp, tag, csr_rdata_o, exp);
  endtask

  task automatic expect_redir(input logic [31:0] t, input logic we, input logic [31:0] ea);
    redir_t e;
    e.target = t; e.we = we; e.ea = ea;
    exp_q.push_back(e);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R9 reset state
    csr_rd(3'd0, 32'h0, "R9 status");
    csr_rd(3'd1, 32'h0, "R9 mask");
    csr_rd(3'd2, 32'h0, "R9 pending");
    csr_rd(3'd3, 32'h0, "R9 base");
    check(redirect_o == 1'b0, "R9 no redirect", {31'b0, redirect_o}, 32'h0);
    csr_rd(3'd5, 32'h0, "R10 unmapped");

    // R1 sticky latch
    irq_i = 32'h20; tick(); irq_i = '0; tick();
    csr_rd(3'd2, 32'h20, "R1 pending sticky");

    // R2 clear while line high: set wins
    irq_i = 32'h20; csr_wr(3'd2, 32'h20); irq_i = '0;
    csr_rd(3'd2, 32'h20, "R2 set wins");
    csr_wr(3'd2, 32'h20);
    csr_rd(3'd2, 32'h0, "R2 cleared");

    // R8 base alignment
    csr_wr(3'd3, 32'h1000_12FF);
    csr_rd(3'd3, 32'h1000_1200, "R8 base low bits dropped");

    // R3 masked-out source causes no entry
    csr_wr(3'd1, 32'h8);
    csr_wr(3'd0, 32'h1);
    irq_i = 32'h80; tick(); irq_i = '0; tick(); tick();
    csr_rd(3'd0, 32'h1, "R3 masked line left enable alone");

    // R3/R4/R5 entry
    pc_next_i = 32'h0000_0400;
    expect_redir(32'h1000_12C0, 1'b1, 32'h0000_0400);
    irq_i = 32'h8; tick(); irq_i = '0; tick();
    csr_rd(3'd0, 32'h2, "R6 enable saved and cleared");
    csr_rd(3'd2, 32'h88, "R6 pending kept");
    tick(); tick();
    check(exp_q.size() == 0, "R3 entry seen", exp_q.size(), 0);

    // R7 return
    csr_wr(3'd2, 32'hFF);
    ea_rdata_i = 32'h0000_0400;
    expect_redir(32'h0000_0400, 1'b0, 32'h0);
    eret_i = 1'b1; tick(); eret_i = 1'b0;
    csr_rd(3'd0, 32'h3, "R7 enable restored");

    // R4 new base, R11 status write during entry
    csr_wr(3'd3, 32'h2000_0000);
    pc_next_i = 32'h0000_0888;
    irq_i = 32'h8; tick(); irq_i = '0;
    expect_redir(32'h2000_00C0, 1'b1, 32'h0000_0888);
    csr_wr(3'd0, 32'h1);
    csr_rd(3'd0, 32'h2, "R11 entry beats status write");

    // R11 status write during return
    csr_wr(3'd2, 32'hFF);
    expect_redir(32'h0000_0400, 1'b0, 32'h0);
    eret_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = 3'd0; csr_wdata_i = 32'h0;
    tick();
    eret_i = 1'b0; csr_we_i = 1'b0;
    csr_rd(3'd0, 32'h3, "R11 return beats status write");

    // R6 saved bit clear: disabled request pends, return keeps enable off
    csr_wr(3'd0, 32'h0);
    irq_i = 32'h8; tick(); irq_i = '0; tick(); tick();
    csr_rd(3'd2, 32'h8, "R6 pend while disabled");
    expect_redir(32'h0000_0400, 1'b0, 32'h0);
    eret_i = 1'b1; tick(); eret_i = 1'b0; tick();
    csr_rd(3'd0, 32'h0, "R7 restore of zero");
    // enabling releases the held request
    expect_redir(32'h2000_00C0, 1'b1, 32'h0000_0888);
    csr_wr(3'd0, 32'h1); tick();
    csr_rd(3'd0, 32'h2, "R3 held request taken on enable");
    tick(); tick();
    check(exp_q.size() == 0, "R3/R7 all redirects seen", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule